// File: doc/BRIEF.md
# Root Port Interrupt Message Queue

This block sits behind a root port's inbound path. It collects two kinds of interrupt events: legacy INTx assertion messages and MSI memory writes. Both kinds go into one queue in arrival order. An MSI write is recognised when its target address equals a 64-bit base that software programs as an upper and a lower 32-bit word. Software reads the oldest event through two read registers. The first register gives a valid flag, a type flag and the INTx line. The second register gives the 16-bit MSI payload. Writing all ones to the first register retires that event.

A second, smaller queue keeps the requester IDs carried by error messages of the correctable, non-fatal and fatal kinds. Software reads it through its own register and pops it the same way. Each queue has a sticky overflow flag. The flag records any event that was lost because the queue was full.

Register reads are combinational from the register address. Reads never change state.

Top module: `irq_msg_queue`

## Requirements
- R1: Register 0x158 shows the oldest interrupt event. Bit 31 is valid. Bit 30 is 1 for an MSI entry and 0 for an INTx entry. Bits 28:27 hold the INTx line (0..3) of an INTx entry. When the queue is empty, bits 31, 30 and 28:27 read 0. All other bits read 0, except the overflow flag of R7.
- R2: Register 0x15C returns, in bits 15:0, the payload (mw_data) of an MSI head entry. It reads 0 when the head is an INTx entry or the queue is empty.
- R3: Registers 0x14C (upper word) and 0x150 (lower word) are writable and read back. An inbound write whose address equals {upper, lower} is queued as an MSI entry. An inbound write to any other address is ignored. A base value takes effect one cycle after it is written.
- R4: Entries leave in arrival order. When an MSI write and an INTx message arrive in the same cycle, both are queued, MSI first.
- R5: Writing 0xFFFFFFFF to 0x158 removes the head entry. Any other value written there, and any write to 0x15C, has no effect. A removal request on an empty queue has no effect.
- R6: Reads never remove an entry. The head stays unchanged until it is removed.
- R7: The interrupt queue holds DEPTH entries (default 16). An event that arrives when the queue is full is discarded and sets a sticky flag at bit 29 of 0x158. A removal in the same cycle does not make room.
- R8: Messages of kind 1 (correctable), 2 (non-fatal) and 3 (fatal) queue msg_rid in the error queue. Kind 0 (INTx) messages never enter it. Register 0x154 shows the error head: bit 18 is valid and bits 15:0 are the requester ID. Writing 0xFFFFFFFF to 0x154 removes the head.
- R9: The error queue holds ERR_DEPTH entries (default 4). An error message that arrives when the error queue is full is discarded and sets a sticky flag at bit 19 of 0x154.
- R10: After reset both queues are empty, both overflow flags are clear and both base words are 0. An event accepted at a clock edge is visible in the registers right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Inbound message present this cycle |
| msg_kind | input | 2 | 0 INTx assert, 1 correctable, 2 non-fatal, 3 fatal |
| msg_line | input | 2 | INTx line of an INTx message |
| msg_rid | input | 16 | Requester ID of an error message |
| mw_valid | input | 1 | Inbound memory write present this cycle |
| mw_addr | input | ADDR_W | Inbound write address |
| mw_data | input | 16 | Low 16 bits of the inbound write payload |
| reg_addr | input | REG_AW | Register byte offset for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
Every queue change, overflow flag and base word is registered once. Its effect appears in reg_rdata right after the clock edge that sampled the stimulus. A register read is combinational, so it is due in the same cycle the address is applied.

The bench holds each stimulus for exactly one cycle, driving it at a falling edge. It then samples the registers after the next falling edge, when the single intervening rising edge has taken effect. For "no effect" cases it waits extra cycles before sampling, so a delayed change would still show up.

// File: rtl/irq_q_pkg.sv
package irq_q_pkg;

  typedef enum logic [1:0] {
    KIND_INTX     = 2'd0,
    KIND_CORR     = 2'd1,
    KIND_NONFATAL = 2'd2,
    KIND_FATAL    = 2'd3
  } msg_kind_e;

  typedef struct packed {
    logic        is_msi;
    logic [1:0]  line;
    logic [15:0] data;
  } irq_entry_t;

  localparam int IRQ_ENTRY_W = $bits(irq_entry_t);
  localparam int RID_W       = 16;

  localparam logic [11:0] OFS_BASE_HI = 12'h14C;
  localparam logic [11:0] OFS_BASE_LO = 12'h150;
  localparam logic [11:0] OFS_ERR     = 12'h154;
  localparam logic [11:0] OFS_IRQ1    = 12'h158;
  localparam logic [11:0] OFS_IRQ2    = 12'h15C;

  localparam logic [31:0] POP_WORD = 32'hFFFF_FFFF;

  function automatic logic [31:0] pack_irq_head(input logic valid, input irq_entry_t e,
                                                input logic ovf);
    logic [31:0] w;
    w        = '0;
    w[31]    = valid;
    w[30]    = valid & e.is_msi;
    w[29]    = ovf;
    w[28:27] = (valid && !e.is_msi) ? e.line : 2'b00;
    return w;
  endfunction

  function automatic logic [31:0] pack_irq_data(input logic valid, input irq_entry_t e);
    return {16'h0, (valid && e.is_msi) ? e.data : 16'h0};
  endfunction

  function automatic logic [31:0] pack_err_head(input logic valid, input logic [RID_W-1:0] rid,
                                                input logic ovf);
    logic [31:0] w;
    w       = '0;
    w[19]   = ovf;
    w[18]   = valid;
    w[15:0] = valid ? rid : 16'h0;
    return w;
  endfunction

  function automatic logic is_error_kind(input msg_kind_e k);
    return (k == KIND_CORR) || (k == KIND_NONFATAL) || (k == KIND_FATAL);
  endfunction

endpackage

// File: rtl/irq_q_fifo.sv
module irq_q_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_a,
  input  logic [W-1:0]  din_a,
  input  logic          push_b,
  input  logic [W-1:0]  din_b,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic          not_empty,
  output logic [CW-1:0] count,
  output logic          drop
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp, wp_b, wp_nxt;
  logic          acc_a, acc_b, pop_eff;
  logic [1:0]    n_in;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    acc_a   = push_a && (count < CW'(DEPTH));
    acc_b   = push_b && ((count + CW'(acc_a)) < CW'(DEPTH));
    pop_eff = pop && (count != '0);
    n_in    = {1'b0, acc_a} + {1'b0, acc_b};
    wp_b    = acc_a ? step(wp) : wp;
    wp_nxt  = acc_b ? step(wp_b) : wp_b;
    drop    = (push_a && !acc_a) || (push_b && !acc_b);
  end

  always_ff @(posedge clk) begin
    if (acc_a) mem[wp]   <= din_a;
    if (acc_b) mem[wp_b] <= din_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp_nxt;
      if (pop_eff) rp <= step(rp);
      count <= count + CW'(n_in) - CW'(pop_eff);
    end
  end

  assign head      = mem[rp];
  assign not_empty = (count != '0);

endmodule

// File: rtl/irq_q_addr_match.sv
module irq_q_addr_match #(
  parameter int ADDR_W = 64
) (
  input  logic [31:0]       base_hi,
  input  logic [31:0]       base_lo,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              hit
);
  localparam int FULL_W = 64;
  logic [FULL_W-1:0] base_full;

  assign base_full = {base_hi, base_lo};
  assign hit       = wr_valid && (wr_addr == base_full[ADDR_W-1:0]);
endmodule

// File: rtl/irq_msg_queue.sv
module irq_msg_queue
  import irq_q_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int ERR_DEPTH = 4,
  parameter int ADDR_W    = 64,
  parameter int REG_AW    = 12,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int ECW      = $clog2(ERR_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  input  logic [1:0]        msg_kind,
  input  logic [1:0]        msg_line,
  input  logic [15:0]       msg_rid,
  input  logic              mw_valid,
  input  logic [ADDR_W-1:0] mw_addr,
  input  logic [15:0]       mw_data,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic [31:0]            base_hi, base_lo;
  logic                   msi_hit, intx_push, err_push;
  logic                   irq_pop, err_pop, irq_drop, err_drop;
  logic                   irq_ovf, err_ovf;
  logic                   irq_nonempty, err_nonempty;
  logic [CW-1:0]          irq_count;
  logic [ECW-1:0]         err_count;
  logic [IRQ_ENTRY_W-1:0] irq_head_bits;
  logic [RID_W-1:0]       err_head;
  irq_entry_t             msi_ent, intx_ent, irq_head;
  msg_kind_e              kind;
  logic                   sel_hi, sel_lo, sel_err, sel_irq1;

  assign kind      = msg_kind_e'(msg_kind);
  assign intx_push = msg_valid && (kind == KIND_INTX);
  assign err_push  = msg_valid && is_error_kind(kind);

  assign sel_hi   = (reg_addr == REG_AW'(OFS_BASE_HI));
  assign sel_lo   = (reg_addr == REG_AW'(OFS_BASE_LO));
  assign sel_err  = (reg_addr == REG_AW'(OFS_ERR));
  assign sel_irq1 = (reg_addr == REG_AW'(OFS_IRQ1));
  assign irq_pop  = reg_we && sel_irq1 && (reg_wdata == POP_WORD);
  assign err_pop  = reg_we && sel_err && (reg_wdata == POP_WORD);

  irq_q_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .base_hi (base_hi),
    .base_lo (base_lo),
    .wr_valid(mw_valid),
    .wr_addr (mw_addr),
    .hit     (msi_hit)
  );

  always_comb begin
    msi_ent  = '{is_msi: 1'b1, line: 2'b00, data: mw_data};
    intx_ent = '{is_msi: 1'b0, line: msg_line, data: 16'h0};
  end

  // lane a (MSI) is ordered ahead of lane b (INTx) within one cycle
  irq_q_fifo #(.W(IRQ_ENTRY_W), .DEPTH(DEPTH)) u_irq_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_a   (msi_hit),
    .din_a    (msi_ent),
    .push_b   (intx_push),
    .din_b    (intx_ent),
    .pop      (irq_pop),
    .head     (irq_head_bits),
    .not_empty(irq_nonempty),
    .count    (irq_count),
    .drop     (irq_drop)
  );

  irq_q_fifo #(.W(RID_W), .DEPTH(ERR_DEPTH)) u_err_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_a   (err_push),
    .din_a    (msg_rid),
    .push_b   (1'b0),
    .din_b    ('0),
    .pop      (err_pop),
    .head     (err_head),
    .not_empty(err_nonempty),
    .count    (err_count),
    .drop     (err_drop)
  );

  assign irq_head = irq_entry_t'(irq_head_bits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_hi <= '0;
      base_lo <= '0;
      irq_ovf <= 1'b0;
      err_ovf <= 1'b0;
    end else begin
      if (reg_we && sel_hi) base_hi <= reg_wdata;
      if (reg_we && sel_lo) base_lo <= reg_wdata;
      if (irq_drop) irq_ovf <= 1'b1;
      if (err_drop) err_ovf <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFS_BASE_HI): reg_rdata = base_hi;
      REG_AW'(OFS_BASE_LO): reg_rdata = base_lo;
      REG_AW'(OFS_ERR):     reg_rdata = pack_err_head(err_nonempty, err_head, err_ovf);
      REG_AW'(OFS_IRQ1):    reg_rdata = pack_irq_head(irq_nonempty, irq_head, irq_ovf);
      REG_AW'(OFS_IRQ2):    reg_rdata = pack_irq_data(irq_nonempty, irq_head);
      default:              reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/irq_msg_queue_chk.sv
module irq_msg_queue_chk #(
  parameter int DEPTH     = 16,
  parameter int ERR_DEPTH = 4,
  parameter int HW        = 19,
  localparam int CW       = $clog2(DEPTH + 1),
  localparam int ECW      = $clog2(ERR_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           msi_hit,
  input logic           intx_push,
  input logic           err_push,
  input logic           irq_pop,
  input logic           err_pop,
  input logic           irq_drop,
  input logic           err_drop,
  input logic           irq_nonempty,
  input logic           err_nonempty,
  input logic [CW-1:0]  irq_count,
  input logic [ECW-1:0] err_count,
  input logic           irq_ovf,
  input logic           err_ovf,
  input logic [HW-1:0]  irq_head,
  input logic [15:0]    err_head
);

  AST_MSI_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_hit && !irq_nonempty) |=> irq_nonempty); // R3

  AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_nonempty && !irq_pop) |=> $stable(irq_head)); // R6

  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_nonempty && irq_pop && !msi_hit && !intx_push) |=> !irq_nonempty); // R5

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_count == CW'(DEPTH) && intx_push) |-> irq_drop); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_count <= CW'(DEPTH)); // R7

  AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drop |=> irq_ovf); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf |=> irq_ovf); // R7

  AST_ERR_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
    (err_push && !err_nonempty) |=> err_nonempty); // R8

  AST_ERR_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (err_nonempty && !err_pop) |=> $stable(err_head)); // R8

  AST_ERR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    err_count <= ECW'(ERR_DEPTH)); // R9

  AST_ERR_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |=> (err_ovf && $past(err_count) == ECW'(ERR_DEPTH))); // R9

endmodule

bind irq_msg_queue irq_msg_queue_chk #(
  .DEPTH    (DEPTH),
  .ERR_DEPTH(ERR_DEPTH),
  .HW       (irq_q_pkg::IRQ_ENTRY_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msi_hit     (msi_hit),
  .intx_push   (intx_push),
  .err_push    (err_push),
  .irq_pop     (irq_pop),
  .err_pop     (err_pop),
  .irq_drop    (irq_drop),
  .err_drop    (err_drop),
  .irq_nonempty(irq_nonempty),
  .err_nonempty(err_nonempty),
  .irq_count   (irq_count),
  .err_count   (err_count),
  .irq_ovf     (irq_ovf),
  .err_ovf     (err_ovf),
  .irq_head    (irq_head_bits),
  .err_head    (err_head)
);

// File: tb/tb_irq_msg_queue.sv
`timescale 1ns/1ps
module tb_irq_msg_queue;

  localparam int DEPTH     = 16;
  localparam int ERR_DEPTH = 4;
  localparam logic [63:0] MSI_ADDR = 64'h0000_0001_FEE0_0000;
  localparam logic [11:0] A_HI = 12'h14C, A_LO = 12'h150, A_ERR = 12'h154,
                          A_R1 = 12'h158, A_R2 = 12'h15C;

  // op[82:80] 0 INTx,1 MSI,2 corr,3 nonfatal,4 fatal | arg[79:64] | exp1 | exp2
  localparam logic [82:0] VEC [8] = '{
    {3'd0, 16'h0000, 32'h8000_0000, 32'h0000_0000},
    {3'd0, 16'h0003, 32'h9800_0000, 32'h0000_0000},
    {3'd0, 16'h0002, 32'h9000_0000, 32'h0000_0000},
    {3'd1, 16'hA5C3, 32'hC000_0000, 32'h0000_A5C3},
    {3'd1, 16'hFFFF, 32'hC000_0000, 32'h0000_FFFF},
    {3'd2, 16'h0123, 32'h0004_0123, 32'h0000_0000},
    {3'd3, 16'hBEEF, 32'h0004_BEEF, 32'h0000_0000},
    {3'd4, 16'hFFFF, 32'h0004_FFFF, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msg_valid;
  logic [1:0]  msg_kind, msg_line;
  logic [15:0] msg_rid;
  logic        mw_valid;
  logic [63:0] mw_addr;
  logic [15:0] mw_data;
  logic [11:0] reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_msg_queue #(.DEPTH(DEPTH), .ERR_DEPTH(ERR_DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
    .msg_line(msg_line), .msg_rid(msg_rid), .mw_valid(mw_valid), .mw_addr(mw_addr),
    .mw_data(mw_data), .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] intx_word(input int line);
    return 32'h8000_0000 | (32'(line) << 27);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    reg_addr = a;
    #0.1;
    v = reg_rdata;
  endtask

  task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic idle_inputs();
    msg_valid = 0; msg_kind = 0; msg_line = 0; msg_rid = 0;
    mw_valid = 0; mw_addr = 0; mw_data = 0; reg_we = 0; reg_wdata = 0;
  endtask

  task automatic cycle_end();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic send_intx(input int line);
    @(negedge clk);
    msg_valid = 1; msg_kind = 2'd0; msg_line = 2'(line);
    cycle_end();
  endtask

  task automatic send_msi(input logic [63:0] a, input logic [15:0] d);
    @(negedge clk);
    mw_valid = 1; mw_addr = a; mw_data = d;
    cycle_end();
  endtask

  task automatic send_err(input int kind, input logic [15:0] rid);
    @(negedge clk);
    msg_valid = 1; msg_kind = 2'(kind); msg_rid = rid;
    cycle_end();
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    cycle_end();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    reg_addr = A_R1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 reset state
    expect_reg("R10 irq head after reset", A_R1, 32'h0);
    expect_reg("R10 msi data after reset", A_R2, 32'h0);
    expect_reg("R10 err head after reset", A_ERR, 32'h0);
    expect_reg("R10 base hi after reset", A_HI, 32'h0);
    expect_reg("R10 base lo after reset", A_LO, 32'h0);

    // R3 program and read back base
    wr(A_HI, MSI_ADDR[63:32]);
    wr(A_LO, MSI_ADDR[31:0]);
    expect_reg("R3 base hi readback", A_HI, MSI_ADDR[63:32]);
    expect_reg("R3 base lo readback", A_LO, MSI_ADDR[31:0]);

    // table walk: R1 R2 R8
    for (int i = 0; i < 8; i++) begin
      int op;
      logic [15:0] arg;
      op  = int'(VEC[i][82:80]);
      arg = VEC[i][79:64];
      if (op == 0) send_intx(int'(arg[1:0]));
      else if (op == 1) send_msi(MSI_ADDR, arg);
      else send_err(op - 1, arg);
      if (op < 2) begin
        expect_reg("R1 head word", A_R1, VEC[i][63:32]);
        expect_reg("R2 msi data", A_R2, VEC[i][31:0]);
        expect_reg("R8 intx not in err q", A_ERR, 32'h0);
        wr(A_R1, 32'hFFFF_FFFF);
        expect_reg("R5 empty after pop", A_R1, 32'h0);
      end else begin
        expect_reg("R8 err head", A_ERR, VEC[i][63:32]);
        expect_reg("R8 err not in irq q", A_R1, VEC[i][31:0]);
        wr(A_ERR, 32'hFFFF_FFFF);
        expect_reg("R8 err empty after pop", A_ERR, 32'h0);
      end
    end

    // R3 non-matching writes ignored
    send_msi(MSI_ADDR + 64'd4, 16'h1234);
    send_msi(MSI_ADDR ^ 64'h1_0000_0000, 16'h1234);
    repeat (2) @(negedge clk);
    expect_reg("R3 mismatched write ignored", A_R1, 32'h0);

    // R4 ordering incl. same-cycle MSI + INTx
    send_intx(1);
    send_msi(MSI_ADDR, 16'h1111);
    send_intx(2);
    @(negedge clk);
    mw_valid = 1; mw_addr = MSI_ADDR; mw_data = 16'h2222;
    msg_valid = 1; msg_kind = 2'd0; msg_line = 2'd3;
    cycle_end();
    expect_reg("R4 order 0", A_R1, intx_word(1));
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R4 order 1", A_R1, 32'hC000_0000);
    expect_reg("R4 order 1 data", A_R2, 32'h0000_1111);
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R4 order 2", A_R1, intx_word(2));
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R4 same cycle msi first", A_R2, 32'h0000_2222);
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R4 same cycle intx second", A_R1, intx_word(3));
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R4 drained", A_R1, 32'h0);

    // R6 reads do not pop; R5 non-pop writes ignored
    send_intx(1);
    expect_reg("R6 read 1", A_R1, intx_word(1));
    repeat (3) @(negedge clk);
    expect_reg("R6 read again", A_R1, intx_word(1));
    wr(A_R1, 32'h0000_0000);
    wr(A_R1, 32'hFFFF_FFFE);
    wr(A_R2, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    expect_reg("R5 partial writes ignored", A_R1, intx_word(1));
    wr(A_R1, 32'hFFFF_FFFF);
    wr(A_R1, 32'hFFFF_FFFF);
    send_intx(0);
    expect_reg("R5 empty pop no effect", A_R1, 32'h8000_0000);
    wr(A_R1, 32'hFFFF_FFFF);
    expect_reg("R5 back to empty", A_R1, 32'h0);

    // R7 overflow
    for (int i = 0; i < DEPTH; i++) send_intx(i % 4);
    expect_reg("R7 full no overflow yet", A_R1, intx_word(0));
    send_intx(3);
    expect_reg("R7 overflow flag set", A_R1, intx_word(0) | 32'h2000_0000);
    @(negedge clk);
    msg_valid = 1; msg_kind = 2'd0; msg_line = 2'd2;
    reg_we = 1; reg_addr = A_R1; reg_wdata = 32'hFFFF_FFFF;
    cycle_end();
    for (int i = 1; i < DEPTH; i++) begin
      expect_reg("R7 retained order", A_R1, intx_word(i % 4) | 32'h2000_0000);
      wr(A_R1, 32'hFFFF_FFFF);
    end
    expect_reg("R7 dropped never stored, flag sticky", A_R1, 32'h2000_0000);

    // R9 error overflow
    for (int i = 0; i < ERR_DEPTH + 1; i++) send_err(1 + (i % 3), 16'h0010 + 16'(i));
    send_intx(0);
    for (int i = 0; i < ERR_DEPTH; i++) begin
      expect_reg("R9 err retained", A_ERR, 32'h000C_0000 | (32'h10 + 32'(i)));
      wr(A_ERR, 32'hFFFF_FFFF);
    end
    expect_reg("R9 err empty, flag sticky", A_ERR, 32'h0008_0000);

    // R10 reset clears flags and queues
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_reg("R10 irq after re-reset", A_R1, 32'h0);
    expect_reg("R10 err after re-reset", A_ERR, 32'h0);
    expect_reg("R10 base cleared", A_LO, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule